// File: doc/BRIEF.md
# Pin Controller with Sticky Change Interrupts

This block is a bank of general-purpose pins that software reaches through a small 32-bit register bus with an address, a write strobe, a read-data return and a ready flag in the style of APB. Every pin has a direction bit and a data bit. The pad side is split into an output-enable vector and a driven-value vector, with a separate vector that brings the pad level back in. Returning levels pass through a multi-flop synchroniser before any logic sees them.

When an input pin changes level in either direction, its bit in a sticky change register is set. Software clears that bit by writing a one to it. A single interrupt request is raised whenever some pin has a recorded change and its enable bit is set. A write-mask register limits which output bits a data write may modify, so software can update one pin without a read-modify-write. The pin count is a parameter from 1 to 32. Register bits above that count always read as zero.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero), `pad_out` is zero, the enable and change registers are zero, `irq` is low, and the write mask at byte offset 0x10 reads as all ones over the implemented pins.
- R2: The direction register at byte offset 0x00 reads back as written. A bit value of 1 makes that pin an output, and `pad_oe` follows the register one cycle after the write.
- R3: A write to the data register at byte offset 0x04 changes only the output bits whose write-mask bit (offset 0x10) is 1. The write mask reads back as written.
- R4: A read of offset 0x04 returns the synchronised pad level of every pin, whatever its direction. An external change shows up there within SYNC_STAGES+1 cycles.
- R5: A rising or a falling edge on a pin whose direction bit is 0 sets that pin's bit in the change register at offset 0x0C, whether or not it is enabled. Level changes on output pins set nothing.
- R6: Writing 1 to a change bit clears it, and writing 0 leaves it as it is. If an edge is recorded in the same cycle that its bit is acknowledged, the bit stays set.
- R7: `irq` is high exactly when some bit is set in both the change register and the enable register at offset 0x08. The enable register reads back as written.
- R8: The trigger-type register at byte offset 0x14 reads as all ones over the implemented pins, meaning both edges, and writes to it have no effect.
- R9: Register bits at or above PIN_COUNT read as zero and ignore writes. Byte offsets with no register read as zero.
- R10: `pready` is high during the access phase (`psel` and `penable` both high) and low during the setup phase, so every transfer takes two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not reading |
| pready | output | 1 | Transfer completes this cycle |
| pad_in | input | PIN_COUNT | Level seen at each pad |
| pad_oe | output | PIN_COUNT | Output enable for each pad |
| pad_out | output | PIN_COUNT | Value driven when enabled |
| irq | output | 1 | Combined change interrupt |

## Verification
The bench builds the bank with 12 pins and the default two-flop synchroniser. With 12 pins, random 32-bit write data always reaches the unimplemented bits 12 to 31, so every write tests that those bits ignore writes and read as zero. Pads loop back through the bench: output pins read their own driven value and input pins read bench-driven levels. Because of this, a direction change can move a pin's level, and the bench checks whether that move is recorded or masked. One directed case aligns an edge with an acknowledge in the same clock cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned OFS_DIR = 'h00;
   localparam int unsigned OFS_DAT = 'h04;
   localparam int unsigned OFS_IEN = 'h08;
   localparam int unsigned OFS_CHG = 'h0C;
   localparam int unsigned OFS_WMK = 'h10;
   localparam int unsigned OFS_TYP = 'h14;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_DIR, SEL_DAT, SEL_IEN, SEL_CHG, SEL_WMK, SEL_TYP
   } reg_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int unsigned N      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pad_in,
   output logic [N-1:0] level,
   output logic [N-1:0] edge_raw
);
   logic [STAGES-1:0][N-1:0] stg_q;
   logic [N-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], pad_in};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign level    = stg_q[STAGES-1];
   assign edge_raw = stg_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pio_change.sv
module pio_change #(
   parameter int unsigned N       = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] edge_raw,
   input  logic [N-1:0] dir,
   input  logic [N-1:0] ien,
   input  logic         ack_we,
   input  logic [N-1:0] ack_bits,
   output logic [N-1:0] chg_q,
   output logic         irq
);
   logic [N-1:0] clr;
   logic         irq_d;

   assign clr   = ack_we ? ack_bits : '0;
   assign irq_d = |(chg_q & ien);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chg_q <= '0;
      else        chg_q <= (chg_q & ~clr) | (edge_raw & ~dir);
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_d;
   end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int unsigned N      = 8,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [BUS_W-1:0]  pwdata,
   input  logic [N-1:0]      level,
   input  logic [N-1:0]      chg_q,
   output logic [BUS_W-1:0]  prdata,
   output logic              pready,
   output logic [N-1:0]      dir_q,
   output logic [N-1:0]      dout_q,
   output logic [N-1:0]      ien_q,
   output logic [N-1:0]      wmask_q,
   output logic              ack_we,
   output logic [N-1:0]      ack_bits
);
   localparam logic [N-1:0] ALL1 = '1;

   reg_sel_e         sel;
   logic             acc, wr;
   logic [N-1:0]     wd;
   logic [BUS_W-1:0] rd;
   logic             unused_wdata_hi;

   assign wd              = pwdata[N-1:0];
   assign unused_wdata_hi = ^pwdata;
   assign acc             = psel & penable;
   assign wr              = acc & pwrite;

   always_comb begin
      case (paddr)
         ADDR_W'(OFS_DIR): sel = SEL_DIR;
         ADDR_W'(OFS_DAT): sel = SEL_DAT;
         ADDR_W'(OFS_IEN): sel = SEL_IEN;
         ADDR_W'(OFS_CHG): sel = SEL_CHG;
         ADDR_W'(OFS_WMK): sel = SEL_WMK;
         ADDR_W'(OFS_TYP): sel = SEL_TYP;
         default:          sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         dout_q  <= '0;
         ien_q   <= '0;
         wmask_q <= ALL1;
      end else if (wr) begin
         case (sel)
            SEL_DIR: dir_q   <= wd;
            SEL_DAT: dout_q  <= (dout_q & ~wmask_q) | (wd & wmask_q);
            SEL_IEN: ien_q   <= wd;
            SEL_WMK: wmask_q <= wd;
            default: ;
         endcase
      end
   end

   assign ack_we   = wr && (sel == SEL_CHG);
   assign ack_bits = wd;

   always_comb begin
      case (sel)
         SEL_DIR: rd = BUS_W'(dir_q);
         SEL_DAT: rd = BUS_W'(level);
         SEL_IEN: rd = BUS_W'(ien_q);
         SEL_CHG: rd = BUS_W'(chg_q);
         SEL_WMK: rd = BUS_W'(wmask_q);
         SEL_TYP: rd = BUS_W'(ALL1);
         default: rd = '0;
      endcase
   end

   assign prdata = (psel && !pwrite) ? rd : '0;
   assign pready = acc;
endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
   parameter int unsigned PIN_COUNT   = 8,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [31:0]          pwdata,
   output logic [31:0]          prdata,
   output logic                 pready,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic                 irq
);
   if (PIN_COUNT < 1 || PIN_COUNT > 32) begin : g_bad_pins
      $error("pio_bank: PIN_COUNT must lie in 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pio_bank: ADDR_W must be at least 5");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_bank: SYNC_STAGES must be at least 2");
   end

   logic [PIN_COUNT-1:0] level, edge_raw;
   logic [PIN_COUNT-1:0] dir_q, dout_q, ien_q, wmask_q, chg_q, ack_bits;
   logic                 ack_we;

   pio_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
      .level(level), .edge_raw(edge_raw)
   );

   pio_regs #(.N(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .level(level), .chg_q(chg_q), .prdata(prdata), .pready(pready),
      .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q), .wmask_q(wmask_q),
      .ack_we(ack_we), .ack_bits(ack_bits)
   );

   pio_change #(.N(PIN_COUNT), .IRQ_REG(IRQ_REG)) u_chg (
      .clk(clk), .rst_n(rst_n), .edge_raw(edge_raw), .dir(dir_q),
      .ien(ien_q), .ack_we(ack_we), .ack_bits(ack_bits),
      .chg_q(chg_q), .irq(irq)
   );

   assign pad_oe  = dir_q;
   assign pad_out = dout_q;
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
   parameter int unsigned N      = 8,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic [31:0]       prdata,
   input logic              pready,
   input logic [N-1:0]      pad_oe,
   input logic [N-1:0]      pad_out,
   input logic [N-1:0]      wmask_q,
   input logic [N-1:0]      chg_q,
   input logic [N-1:0]      dir_q,
   input logic [N-1:0]      edge_raw
);
   localparam logic [31:0] IMPL = 32'((64'd1 << N) - 64'd1);

   logic         wr;
   logic [N-1:0] in_edge;
   assign wr      = psel && penable && pwrite;
   assign in_edge = edge_raw & ~dir_q;

   assert_setup_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |-> !pready);

   assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == ADDR_W'('h00)) |=> (pad_oe == $past(pwdata[N-1:0])));

   assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == ADDR_W'('h04)) |=>
      (((pad_out ^ $past(pad_out)) & ~$past(wmask_q)) == '0));

   assert_edge_records_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_edge != '0) |=> ((chg_q & $past(in_edge)) == $past(in_edge)));

   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == ADDR_W'('h0C) && in_edge == '0) |=>
      ((chg_q & $past(pwdata[N-1:0])) == '0));

   assert_type_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !pwrite && paddr == ADDR_W'('h14)) |-> (prdata == IMPL));

   assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !pwrite) |-> ((prdata & ~IMPL) == 32'd0));
endmodule

bind pio_bank pio_bank_chk #(.N(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
   .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
   .pready(pready), .pad_oe(pad_oe), .pad_out(pad_out),
   .wmask_q(wmask_q), .chg_q(chg_q), .dir_q(dir_q), .edge_raw(edge_raw)
);

// File: tb/tb_pio_bank.sv
module tb_pio_bank;
   localparam int  N       = 12;
   localparam int  AW      = 5;
   localparam time CLK_PER = 10ns;
   localparam logic [31:0] IMPL = 32'((64'd1 << N) - 64'd1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic          pready;
   logic [N-1:0]  pad_in, pad_oe, pad_out, ext = '0;
   logic          irq;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_dir = 0, m_out = 0, m_en = 0, m_chg = 0, m_wm = IMPL;

   always #(CLK_PER/2) clk = ~clk;
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   pio_bank #(.PIN_COUNT(N), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pad_in(pad_in), .pad_oe(pad_oe),
      .pad_out(pad_out), .irq(irq)
   );

   function automatic logic [31:0] lvl();
      return ((m_dir & m_out) | (~m_dir & 32'(ext))) & IMPL;
   endfunction

   function automatic logic [31:0] exp_reg(input logic [4:0] a);
      case (a)
         5'h00: return m_dir;
         5'h04: return lvl();
         5'h08: return m_en;
         5'h0C: return m_chg;
         5'h10: return m_wm;
         5'h14: return IMPL;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic bus(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = AW'(a); pwdata = d;
      #1; check("R10 setup", 32'(pready), 32'd0);
      @(negedge clk);
      penable = 1'b1;
      #1; rd = prdata;
      check("R10 access", 32'(pready), 32'd1);
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
   endtask

   // model-tracked register write followed by settling of pad edges
   task automatic mwrite(input logic [4:0] a, input logic [31:0] d);
      logic [31:0] old, nw, rd;
      old = lvl();
      case (a)
         5'h00: m_dir = d & IMPL;
         5'h04: m_out = (m_out & ~m_wm) | (d & m_wm & IMPL);
         5'h08: m_en  = d & IMPL;
         5'h0C: m_chg = m_chg & ~d;
         5'h10: m_wm  = d & IMPL;
         default: ;
      endcase
      bus(1'b1, a, d, rd);
      settle();
      nw = lvl();
      m_chg = m_chg | ((old ^ nw) & ~m_dir & IMPL);
   endtask

   task automatic mext(input logic [N-1:0] v);
      logic [31:0] old, nw;
      old = lvl();
      @(negedge clk); ext = v;
      settle();
      nw = lvl();
      m_chg = m_chg | ((old ^ nw) & ~m_dir & IMPL);
   endtask

   task automatic check_all(input string tag);
      logic [31:0] rd;
      bus(1'b0, 5'h00, 0, rd); check({"R2 dir ", tag}, rd, exp_reg(5'h00));
      bus(1'b0, 5'h04, 0, rd); check({"R4 data ", tag}, rd, exp_reg(5'h04));
      bus(1'b0, 5'h08, 0, rd); check({"R7 ien ", tag}, rd, exp_reg(5'h08));
      bus(1'b0, 5'h0C, 0, rd); check({"R5 chg ", tag}, rd, exp_reg(5'h0C));
      bus(1'b0, 5'h10, 0, rd); check({"R3 wmask ", tag}, rd, exp_reg(5'h10));
      bus(1'b0, 5'h14, 0, rd); check({"R8 type ", tag}, rd, IMPL);
      bus(1'b0, 5'h18, 0, rd); check({"R9 hole ", tag}, rd, 32'd0);
      @(negedge clk);
      check({"R2 oe ", tag}, 32'(pad_oe), m_dir);
      check({"R3 out ", tag}, 32'(pad_out), m_out & IMPL);
      check({"R7 irq ", tag}, 32'(irq), 32'(|(m_chg & m_en)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd7391));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check("R1 oe", 32'(pad_oe), 0);
      check("R1 out", 32'(pad_out), 0);
      check("R1 irq", 32'(irq), 0);
      bus(1'b0, 5'h10, 0, rd); check("R1 wmask", rd, IMPL);
      check_all("reset R1");

      // R8 write to type ignored, R9 upper bits ignored
      mwrite(5'h14, 32'h0);
      mwrite(5'h00, 32'hFFFF_F00F);
      check_all("upper R9");

      // R5 edges on input pins, R7 enable gating
      mwrite(5'h00, 32'h0);
      mext(12'h00F);
      check_all("rise R5");
      mext(12'h005);
      check_all("fall R5");
      mwrite(5'h08, 32'h002);
      check_all("en R7");
      // R6 write zero leaves, write one clears
      mwrite(5'h0C, 32'h0);
      check_all("ack0 R6");
      mwrite(5'h0C, 32'h00A);
      check_all("ack1 R6");

      // R6 collision: edge on pin 0 recorded in the cycle its ack lands
      mext(12'h004);          // pin0 fell; chg bits 0 set
      @(negedge clk); ext = 12'h005;
      bus(1'b1, 5'h0C, 32'h1, rd);
      settle();
      bus(1'b0, 5'h0C, 0, rd);
      check("R6 set wins", rd & 32'h1, 32'h1);
      m_chg = m_chg | 32'h1;
      check_all("collide R6");

      // R3 write mask
      mwrite(5'h00, 32'hFFF);
      mwrite(5'h10, 32'h0F0);
      mwrite(5'h04, 32'hFFF);
      check_all("mask R3");
      mwrite(5'h10, 32'hFFF);
      mwrite(5'h04, 32'h0A5);
      check_all("full R3");
      // R5 output pin level changes are not recorded, then turn to input
      mwrite(5'h0C, 32'hFFFF_FFFF);
      mwrite(5'h04, 32'hF5A);
      check_all("outpin R5");
      mwrite(5'h00, 32'h000);
      check_all("toinput R5");

      // constrained random mix
      for (int i = 0; i < 250; i++) begin
         int op = $urandom_range(0, 6);
         logic [31:0] d = $urandom;
         case (op)
            0: mwrite(5'h00, d);
            1: mwrite(5'h04, d);
            2: mwrite(5'h08, d);
            3: mwrite(5'h0C, d);
            4: mwrite(5'h10, d);
            5: mwrite(5'h14, d);
            default: mext(ext ^ N'(d));
         endcase
         check_all("random R4");
      end
      finish_run();
   end
endmodule